// File: doc/BRIEF.md
# DDR3 Read Burst Timing Sequencer

This block runs on the memory clock and turns accepted READ commands into the per-clock return schedule that a DDR3 device would produce. For each clock it gives a data-valid flag, the column offsets of the rising-edge and falling-edge beats, the bank and base column of the burst being returned, a strobe-drive enable, and single-clock preamble and postamble markers around each strobe window.

The burst length comes from a two-bit mode field that is written through a load strobe. It can also be chosen per command from the A12 bit. Read latency is RL = CL + AL, where CL and AL are parameters. A shift line of RL + 4 slots holds reads that are still in flight, so a new READ can be taken while earlier data is still returning. Reads spaced exactly tCCD apart with 8-beat bursts merge into one continuous strobe window. Chopped bursts stay separately framed.

Top module: `ddr3_rd_sequencer`

## Requirements
- R1: While reset is held, every output is low. After reset, READ commands are ignored and produce no output activity until a mode value of 00, 01 or 10 has been loaded.
- R2: A READ sampled at clock edge k is accepted when the mode is valid and the spacing rule holds. For an accepted READ, dq_valid first goes high after edge k+RL, with RL = CL + AL (5 by default).
- R3: With mode 00 loaded, every accepted READ gives 4 consecutive data clocks (8 beats). With mode 10 loaded, it gives 2 data clocks (4 beats). In both modes rd_a12 has no effect.
- R4: With mode 01 loaded, rd_a12 = 1 on a READ gives 4 data clocks and rd_a12 = 0 gives 2 data clocks.
- R5: In data clock i of a burst (i counting from 0), rise_off = 2i and fall_off = 2i+1. During the burst, out_bank and out_col hold the READ's bank and column. While dq_valid is low, rise_off, fall_off, out_bank and out_col are 0.
- R6: A READ sampled fewer than TCCD (4) edges after the last accepted READ is not scheduled. It raises proto_err for exactly the one clock after that edge, and it does not restart the spacing count.
- R7: preamble is high in exactly those clocks where dq_valid is low and dq_valid is high in the next clock.
- R8: postamble is high in exactly those clocks where dq_valid is low and dq_valid was high in the previous clock. When there is a single idle clock between two bursts, preamble and postamble are both high in that clock.
- R9: dqs_oe is high exactly when dq_valid, preamble or postamble is high.
- R10: Two 8-beat READs accepted exactly TCCD edges apart give 8 continuous data clocks. There is one preamble before them and one postamble after them. Two 4-beat READs accepted TCCD apart are separated by two idle clocks, each burst with its own preamble and postamble.
- R11: Loading mode value 11 raises mode_err for the one clock after the load edge. The previously loaded mode, or the not-yet-loaded state, stays in force.
- R12: A burst that has already been accepted returns unchanged, whatever READs or mode loads arrive while it is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_load | input | 1 | Load strobe for the burst-length mode field |
| mode_val | input | 2 | Mode field: 00 fixed 8-beat, 01 per-command, 10 fixed 4-beat, 11 reserved |
| rd_cmd | input | 1 | READ command strobe |
| rd_bank | input | BANK_W | Bank of the READ |
| rd_col | input | COL_W | Starting column of the READ |
| rd_a12 | input | 1 | Per-command burst select used in mode 01 (1 = 8 beats) |
| dq_valid | output | 1 | A data clock carrying two beats |
| rise_off | output | 3 | Column offset of the rising-edge beat |
| fall_off | output | 3 | Column offset of the falling-edge beat |
| out_bank | output | BANK_W | Bank of the burst being returned |
| out_col | output | COL_W | Base column of the burst being returned |
| dqs_oe | output | 1 | Strobe drive enable |
| preamble | output | 1 | Clock before the first data clock of a strobe window |
| postamble | output | 1 | Clock after the last data clock of a strobe window |
| proto_err | output | 1 | One-clock flag for a READ that breaks the spacing rule |
| mode_err | output | 1 | One-clock flag for a load of the reserved mode value |

## Verification
The assertions take for granted that the inputs are known values once rst_n is high. They also assume that each command or load strobe is held for exactly one clock, so that every error flag can be traced to the edge before it. The bench drives every input from a negative-edge task that presents at most one action per clock: a mode load, a READ or idle. It never loads a mode in the same clock as a READ. Its sweep covers every mode value, every pair of A12 settings and command spacings from 2 to 7 clocks, which reaches spacings on both sides of tCCD without breaking these assumptions.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [1:0] {
    BLM_FIXED8 = 2'b00,
    BLM_ONFLY  = 2'b01,
    BLM_CHOP4  = 2'b10,
    BLM_RSVD   = 2'b11
  } bl_mode_e;
endpackage

// File: rtl/rdseq_mode_ctl.sv
module rdseq_mode_ctl
  import rdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] val,
  input  logic       a12,
  output logic       mode_ok,
  output logic       burst8,
  output logic       mode_err
);
  bl_mode_e mode_q, mode_d;
  logic     ok_q, ok_d;
  logic     err_q, err_d;

  always_comb begin
    mode_d = mode_q;
    ok_d   = ok_q;
    err_d  = 1'b0;
    if (load) begin
      if (bl_mode_e'(val) == BLM_RSVD) begin
        err_d = 1'b1;
      end else begin
        mode_d = bl_mode_e'(val);
        ok_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= BLM_FIXED8;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    case (mode_q)
      BLM_FIXED8: burst8 = 1'b1;
      BLM_ONFLY:  burst8 = a12;
      default:    burst8 = 1'b0;
    endcase
  end

  assign mode_ok  = ok_q;
  assign mode_err = err_q;
endmodule

// File: rtl/rdseq_ccd_gate.sv
module rdseq_ccd_gate #(
  parameter int TCCD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic accept,
  output logic proto_err
);
  localparam int CW = $clog2(TCCD + 1);

  logic [CW-1:0] gap_q, gap_d;
  logic          err_q, err_d;
  logic          room;

  assign room   = (gap_q == CW'(TCCD));
  assign accept = req & room;

  always_comb begin
    gap_d = gap_q;
    if (accept)     gap_d = CW'(1);
    else if (!room) gap_d = gap_q + 1'b1;
    err_d = req & ~room;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= CW'(TCCD);
      err_q <= 1'b0;
    end else begin
      gap_q <= gap_d;
      err_q <= err_d;
    end
  end

  assign proto_err = err_q;
endmodule

// File: rtl/rdseq_slot_line.sv
module rdseq_slot_line #(
  parameter int RL     = 5,
  parameter int DEPTH  = 9,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              burst8,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  output logic              head_v,
  output logic [1:0]        head_idx,
  output logic [BANK_W-1:0] head_bank,
  output logic [COL_W-1:0]  head_col,
  output logic              next_v
);
  typedef struct packed {
    logic              v;
    logic [1:0]        idx;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } slot_t;

  slot_t line_q [DEPTH];
  slot_t line_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    localparam int K = i - (RL - 1);
    slot_t shifted;
    if (i == DEPTH - 1) begin : g_tail
      assign shifted = '0;
    end else begin : g_body
      assign shifted = line_q[i+1];
    end
    if (K >= 0 && K < 4) begin : g_load
      logic take;
      assign take = accept & (burst8 | (K < 2));
      always_comb begin
        if (take) line_d[i] = '{v: 1'b1, idx: 2'(K), bank: bank, col: col};
        else      line_d[i] = shifted;
      end
    end else begin : g_pass
      always_comb line_d[i] = shifted;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[i] <= '0;
      else        line_q[i] <= line_d[i];
    end
  end

  assign head_v    = line_q[0].v;
  assign head_idx  = line_q[0].idx;
  assign head_bank = line_q[0].bank;
  assign head_col  = line_q[0].col;
  assign next_v    = line_q[1].v;
endmodule

// File: rtl/rdseq_framer.sv
module rdseq_framer #(
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_v,
  input  logic [1:0]        head_idx,
  input  logic [BANK_W-1:0] head_bank,
  input  logic [COL_W-1:0]  head_col,
  input  logic              next_v,
  output logic              dq_valid,
  output logic [2:0]        rise_off,
  output logic [2:0]        fall_off,
  output logic [BANK_W-1:0] out_bank,
  output logic [COL_W-1:0]  out_col,
  output logic              dqs_oe,
  output logic              preamble,
  output logic              postamble
);
  logic              dv_q, pre_q, post_q, oe_q;
  logic              dv_d, pre_d, post_d, oe_d;
  logic [2:0]        rise_q, fall_q, rise_d, fall_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;

  always_comb begin
    dv_d   = head_v;
    pre_d  = next_v & ~head_v;
    post_d = dv_q & ~head_v;
    oe_d   = head_v | pre_d | post_d;
    rise_d = head_v ? {head_idx, 1'b0} : 3'd0;
    fall_d = head_v ? {head_idx, 1'b1} : 3'd0;
    bank_d = head_v ? head_bank : '0;
    col_d  = head_v ? head_col  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      pre_q  <= 1'b0;
      post_q <= 1'b0;
      oe_q   <= 1'b0;
      rise_q <= 3'd0;
      fall_q <= 3'd0;
      bank_q <= '0;
      col_q  <= '0;
    end else begin
      dv_q   <= dv_d;
      pre_q  <= pre_d;
      post_q <= post_d;
      oe_q   <= oe_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      bank_q <= bank_d;
      col_q  <= col_d;
    end
  end

  assign dq_valid  = dv_q;
  assign preamble  = pre_q;
  assign postamble = post_q;
  assign dqs_oe    = oe_q;
  assign rise_off  = rise_q;
  assign fall_off  = fall_q;
  assign out_bank  = bank_q;
  assign out_col   = col_q;
endmodule

// File: rtl/ddr3_rd_sequencer.sv
module ddr3_rd_sequencer #(
  parameter int CL     = 5,
  parameter int AL     = 0,
  parameter int TCCD   = 4,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [1:0]        mode_val,
  input  logic              rd_cmd,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_a12,
  output logic              dq_valid,
  output logic [2:0]        rise_off,
  output logic [2:0]        fall_off,
  output logic [BANK_W-1:0] out_bank,
  output logic [COL_W-1:0]  out_col,
  output logic              dqs_oe,
  output logic              preamble,
  output logic              postamble,
  output logic              proto_err,
  output logic              mode_err
);
  localparam int RL    = CL + AL;
  localparam int DEPTH = RL + 4;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              mode_ok, burst8, accept;
  logic              head_v, next_v;
  logic [1:0]        head_idx;
  logic [BANK_W-1:0] head_bank;
  logic [COL_W-1:0]  head_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rdseq_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_int_n), .load(mode_load), .val(mode_val), .a12(rd_a12),
    .mode_ok(mode_ok), .burst8(burst8), .mode_err(mode_err)
  );

  rdseq_ccd_gate #(.TCCD(TCCD)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .req(rd_cmd & mode_ok),
    .accept(accept), .proto_err(proto_err)
  );

  rdseq_slot_line #(.RL(RL), .DEPTH(DEPTH), .BANK_W(BANK_W), .COL_W(COL_W)) u_line (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .burst8(burst8),
    .bank(rd_bank), .col(rd_col),
    .head_v(head_v), .head_idx(head_idx), .head_bank(head_bank),
    .head_col(head_col), .next_v(next_v)
  );

  rdseq_framer #(.BANK_W(BANK_W), .COL_W(COL_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .head_v(head_v), .head_idx(head_idx),
    .head_bank(head_bank), .head_col(head_col), .next_v(next_v),
    .dq_valid(dq_valid), .rise_off(rise_off), .fall_off(fall_off),
    .out_bank(out_bank), .out_col(out_col), .dqs_oe(dqs_oe),
    .preamble(preamble), .postamble(postamble)
  );
endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
  parameter int TCCD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_load,
  input logic [1:0] mode_val,
  input logic       rd_cmd,
  input logic       accept,
  input logic       dq_valid,
  input logic [2:0] rise_off,
  input logic [2:0] fall_off,
  input logic       dqs_oe,
  input logic       preamble,
  input logic       postamble,
  input logic       proto_err,
  input logic       mode_err
);
  int since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_acc <= TCCD;
    else if (accept)         since_acc <= 1;
    else if (since_acc < TCCD) since_acc <= since_acc + 1;
  end

  p_ccd_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> since_acc >= TCCD);

  p_proto_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(rd_cmd));

  p_pre_then_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preamble |=> dq_valid);

  p_post_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    postamble |-> ($past(dq_valid) && !dq_valid));

  p_strobe_covers_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dqs_oe);

  p_offset_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && $past(dq_valid)) |-> ((rise_off == $past(rise_off) + 3'd2) || (rise_off == 3'd0)));

  p_idle_offsets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> (rise_off == 3'd0 && fall_off == 3'd0));

  p_mode_err_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> ($past(mode_load) && $past(mode_val) == 2'b11));
endmodule

bind ddr3_rd_sequencer rdseq_checker #(.TCCD(TCCD)) u_rdseq_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_val(mode_val),
  .rd_cmd(rd_cmd), .accept(accept), .dq_valid(dq_valid), .rise_off(rise_off),
  .fall_off(fall_off), .dqs_oe(dqs_oe), .preamble(preamble), .postamble(postamble),
  .proto_err(proto_err), .mode_err(mode_err)
);

// File: tb/ddr3_rd_sequencer_bench.sv
module ddr3_rd_sequencer_bench;
  localparam int CL = 5, AL = 0, RL = CL + AL, TCCD = 4, BW = 3, CW = 10, N = 4096;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, mode_load, rd_cmd, rd_a12;
  logic [1:0]    mode_val;
  logic [BW-1:0] rd_bank;
  logic [CW-1:0] rd_col;
  logic          dq_valid, dqs_oe, preamble, postamble, proto_err, mode_err;
  logic [2:0]    rise_off, fall_off;
  logic [BW-1:0] out_bank;
  logic [CW-1:0] out_col;

  ddr3_rd_sequencer #(.CL(CL), .AL(AL), .TCCD(TCCD), .BANK_W(BW), .COL_W(CW)) u_ddr3_rd_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_val(mode_val),
    .rd_cmd(rd_cmd), .rd_bank(rd_bank), .rd_col(rd_col), .rd_a12(rd_a12),
    .dq_valid(dq_valid), .rise_off(rise_off), .fall_off(fall_off),
    .out_bank(out_bank), .out_col(out_col), .dqs_oe(dqs_oe),
    .preamble(preamble), .postamble(postamble), .proto_err(proto_err), .mode_err(mode_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit            exp_dv   [N];
  logic [1:0]    exp_idx  [N];
  logic [BW-1:0] exp_bank [N];
  logic [CW-1:0] exp_col  [N];
  bit            exp_perr [N];
  bit            exp_merr [N];

  int checks = 0, fails = 0;
  bit checking = 1'b0, finished = 1'b0;
  bit m_ok = 1'b0;
  logic [1:0] m_mode = 2'b00;
  int last_acc = -100;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !finished) begin
      automatic int  t    = cyc;
      automatic bit  dv   = exp_dv[t];
      automatic bit  prv  = (t > 0) ? exp_dv[t-1] : 1'b0;
      automatic bit  pre  = !dv && exp_dv[t+1];
      automatic bit  post = !dv && prv;
      chk("R1 R2 R3 R4 R12 dq_valid", 16'(dq_valid), 16'(dv));
      chk("R5 rise_off", 16'(rise_off), dv ? 16'({exp_idx[t], 1'b0}) : 16'd0);
      chk("R5 fall_off", 16'(fall_off), dv ? 16'({exp_idx[t], 1'b1}) : 16'd0);
      chk("R5 R12 out_bank", 16'(out_bank), dv ? 16'(exp_bank[t]) : 16'd0);
      chk("R5 R12 out_col", 16'(out_col), dv ? 16'(exp_col[t]) : 16'd0);
      chk("R7 R10 preamble", 16'(preamble), 16'(pre));
      chk("R8 R10 postamble", 16'(postamble), 16'(post));
      chk("R9 dqs_oe", 16'(dqs_oe), 16'(dv | pre | post));
      chk("R6 proto_err", 16'(proto_err), 16'(exp_perr[t]));
      chk("R11 mode_err", 16'(mode_err), 16'(exp_merr[t]));
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      mode_load = 1'b0;
      rd_cmd    = 1'b0;
    end
  endtask

  task automatic load_mode(logic [1:0] v);
    @(negedge clk);
    rd_cmd    = 1'b0;
    mode_load = 1'b1;
    mode_val  = v;
    if (v == 2'b11) exp_merr[cyc+1] = 1'b1;
    else begin
      m_ok   = 1'b1;
      m_mode = v;
    end
  endtask

  task automatic read(logic a12, logic [BW-1:0] b, logic [CW-1:0] c);
    automatic int e;
    automatic int len;
    @(negedge clk);
    mode_load = 1'b0;
    rd_cmd    = 1'b1;
    rd_a12    = a12;
    rd_bank   = b;
    rd_col    = c;
    e = cyc + 1;
    if (m_ok) begin
      if (e - last_acc >= TCCD) begin
        last_acc = e;
        len = (m_mode == 2'b00 || (m_mode == 2'b01 && a12)) ? 4 : 2;
        for (int j = 0; j < len; j++) begin
          exp_dv[e+RL+j]   = 1'b1;
          exp_idx[e+RL+j]  = 2'(j);
          exp_bank[e+RL+j] = b;
          exp_col[e+RL+j]  = c;
        end
      end else begin
        exp_perr[e] = 1'b1;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; rd_cmd = 1'b0; rd_a12 = 1'b0;
    mode_val = 2'b00; rd_bank = '0; rd_col = '0;
    repeat (2) @(negedge clk);
    checking = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: reads before any mode load are ignored
    read(1'b1, 3'd1, 10'd40);
    idle(5);
    read(1'b0, 3'd2, 10'd44);
    idle(RL + 6);
    // R11: reserved load while unconfigured keeps block idle
    load_mode(2'b11);
    idle(2);
    read(1'b1, 3'd3, 10'd48);
    idle(RL + 6);
    // R3 R4 R6 R10: sweep mode x A12 pair x spacing
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < 4; a++) begin
        for (int sp = 2; sp < 8; sp++) begin
          load_mode(2'(m));
          idle(2);
          read(a[0], 3'(sp), 10'(m * 97 + a * 13 + sp * 8));
          idle(sp - 1);
          read(a[1], 3'(a + 3), 10'(m * 97 + a * 13 + sp * 8 + 512));
          if (sp < TCCD) begin
            idle(TCCD - sp - 1);
            read(~a[0], 3'(7 - sp), 10'(sp * 31 + 5));
          end
          idle(RL + 8);
        end
      end
    end
    // R11 R12: reserved load keeps 8-beat mode; mode change mid-burst
    load_mode(2'b00);
    idle(2);
    read(1'b0, 3'd5, 10'd600);
    load_mode(2'b11);
    idle(1);
    read(1'b0, 3'd6, 10'd608);
    load_mode(2'b10);
    idle(3);
    read(1'b1, 3'd7, 10'd616);
    idle(RL + 10);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog all-requirements act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule